// File: doc/BRIEF.md
# Programmable Pulse-Per-Second Generator

This block drives a single periodic pulse line from a running 64-bit time value. The time value is in 32.32 fixed-point nanoseconds: the upper 32 bits count whole nanoseconds and the lower 32 bits hold the fraction. The block keeps an internal level and a 64-bit edge threshold. When the incoming time reaches or passes the threshold, the level flips. The threshold then moves forward by the length of the phase that just began. High and low phases each have their own programmable length, so one pair of settings gives both the period and the duty cycle. Loading 500,000,000 ns (0x1DCD6500_00000000) into both lengths gives a 1 Hz square wave with a 50 % duty cycle.

Software programs the block through a 64-bit write port. A 2-bit selector on that port addresses a control word (enable and polarity invert), the two phase lengths and the threshold. The time counter itself is outside the block and arrives on an input.

Top module: `ppsg_top`

## Requirements
- R1: While reset is active, and after it is released, the level is low, the threshold is zero, both phase lengths are zero and enable and invert are clear, so `pps_out` is 0.
- R2: While enable is 0, `pps_out` equals the invert bit. The level and threshold do not change, and they resume from their held values once enable is set again.
- R3: While enabled, a clock edge on which `time_now` >= threshold (unsigned, full 64 bits) and no threshold write occurs flips the level. When `time_now` < threshold, the level and threshold hold.
- R4: On each flip the threshold grows by the high length if the new level is 1, or by the low length if it is 0. Both lengths are the values held before that edge, and the sum wraps modulo 2^64.
- R5: While enabled, `pps_out` equals level XOR invert. It reflects a flip or a control write from the clock edge on which that flip or write happens.
- R6: A threshold write loads the written value on that edge and suppresses any flip and reload on that same edge.
- R7: A threshold that lies behind the time fires on consecutive edges, once per edge, until reloads carry it past `time_now`.
- R8: The write port encoding is: `wr_sel` 0 is the control word (bit 0 enable, bit 1 invert), 1 is the high length, 2 is the low length and 3 is the threshold. With `wr_en` low, the port has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| time_now | input | TIME_W | Current time, 32.32 fixed-point ns |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (see R8) |
| wr_data | input | TIME_W | Write data |
| pps_out | output | 1 | Pulse output |

## Verification
The assertions assume that `time_now`, `wr_en`, `wr_sel` and `wr_data` are stable around each rising edge. They also assume `time_now` is a defined value on every cycle, because the compare and reload checks sample it together with the threshold. The bench changes every input only at the falling edge and drives a defined time value from reset onward. It sweeps several high and low lengths with fractional parts against a time step of 0.75 ns. It also drives the cases where the time lies far ahead of the threshold, where the threshold wraps past 2^64, and where a threshold write lands on a firing edge.

// File: rtl/ppsg_pkg.sv
package ppsg_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_HI   = 2'd1,
    SEL_LO   = 2'd2,
    SEL_THR  = 2'd3
  } ppsg_sel_e;

  typedef struct packed {
    logic invert;
    logic enable;
  } ppsg_ctrl_t;

endpackage

// File: rtl/ppsg_cfg_regs.sv
module ppsg_cfg_regs
  import ppsg_pkg::*;
#(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [TIME_W-1:0] wr_data,
  output ppsg_ctrl_t        ctrl,
  output logic [TIME_W-1:0] hi_len,
  output logic [TIME_W-1:0] lo_len,
  output logic              thr_wr
);

  localparam int unsigned CTRL_W = $bits(ppsg_ctrl_t);

  ppsg_sel_e         sel;
  ppsg_ctrl_t        ctrl_q, ctrl_d;
  logic [TIME_W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic              ctrl_ce, hi_ce, lo_ce;

  always_comb begin
    sel     = ppsg_sel_e'(wr_sel);
    ctrl_ce = wr_en && (sel == SEL_CTRL);
    hi_ce   = wr_en && (sel == SEL_HI);
    lo_ce   = wr_en && (sel == SEL_LO);
    thr_wr  = wr_en && (sel == SEL_THR);
    ctrl_d  = ppsg_ctrl_t'(wr_data[CTRL_W-1:0]);
    hi_d    = wr_data;
    lo_d    = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      if (ctrl_ce) ctrl_q <= ctrl_d;
      if (hi_ce)   hi_q   <= hi_d;
      if (lo_ce)   lo_q   <= lo_d;
    end
  end

  assign ctrl   = ctrl_q;
  assign hi_len = hi_q;
  assign lo_len = lo_q;

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q) && $stable(hi_q) && $stable(lo_q)); // R8

endmodule

// File: rtl/ppsg_phase_gen.sv
module ppsg_phase_gen #(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [TIME_W-1:0] time_now,
  input  logic [TIME_W-1:0] hi_len,
  input  logic [TIME_W-1:0] lo_len,
  input  logic              thr_wr,
  input  logic [TIME_W-1:0] thr_wdata,
  output logic              level
);

  logic [TIME_W-1:0] thr_q, thr_d;
  logic              lvl_q, lvl_d;
  logic              due, fire;

  always_comb begin
    due   = (time_now >= thr_q);
    fire  = enable && due && !thr_wr;
    lvl_d = lvl_q;
    thr_d = thr_q;
    if (thr_wr) begin
      thr_d = thr_wdata;
    end else if (fire) begin
      lvl_d = !lvl_q;
      thr_d = thr_q + (lvl_q ? lo_len : hi_len);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      thr_q <= '0;
    end else begin
      lvl_q <= lvl_d;
      thr_q <= thr_d;
    end
  end

  assign level = lvl_q;

  AST_THR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> (thr_q == $past(thr_wdata)) && $stable(lvl_q)); // R6

  AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !thr_wr) |=> $stable(lvl_q) && $stable(thr_q)); // R2

  AST_EDGE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !thr_wr && time_now >= thr_q) |=> lvl_q != $past(lvl_q)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!thr_wr && time_now < thr_q) |=> $stable(lvl_q) && $stable(thr_q)); // R3

  AST_RELOAD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !thr_wr && time_now >= thr_q) |=>
      thr_q == $past(thr_q) + ($past(lvl_q) ? $past(lo_len) : $past(hi_len))); // R4

endmodule

// File: rtl/ppsg_top.sv
module ppsg_top
  import ppsg_pkg::*;
#(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] time_now,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [TIME_W-1:0] wr_data,
  output logic              pps_out
);

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  ppsg_ctrl_t             ctrl;
  logic [TIME_W-1:0]      hi_len, lo_len;
  logic                   thr_wr, level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  ppsg_cfg_regs #(.TIME_W(TIME_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .ctrl    (ctrl),
    .hi_len  (hi_len),
    .lo_len  (lo_len),
    .thr_wr  (thr_wr)
  );

  ppsg_phase_gen #(.TIME_W(TIME_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .enable    (ctrl.enable),
    .time_now  (time_now),
    .hi_len    (hi_len),
    .lo_len    (lo_len),
    .thr_wr    (thr_wr),
    .thr_wdata (wr_data),
    .level     (level)
  );

  assign pps_out = ctrl.enable ? (level ^ ctrl.invert) : ctrl.invert;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_int_n |-> !pps_out); // R1

endmodule

// File: tb/tb_ppsg_top.sv
module tb_ppsg_top;

  localparam int unsigned TW = 64;
  localparam logic [TW-1:0] NS = 64'h1_0000_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] time_now = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic [TW-1:0] wr_data = '0;
  logic          pps_out;

  int checks = 0;
  int fails  = 0;

  logic          m_lvl = 1'b0, m_en = 1'b0, m_inv = 1'b0;
  logic [TW-1:0] m_thr = '0, m_hi = '0, m_lo = '0;

  ppsg_top #(.TIME_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .time_now(time_now),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .pps_out(pps_out)
  );

  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // reference update for one rising edge, from the requirements
  task automatic model_edge();
    logic fire;
    logic [TW-1:0] hi_old, lo_old;
    hi_old = m_hi;
    lo_old = m_lo;
    if (!rst_n) begin
      m_lvl = 0; m_thr = '0; m_hi = '0; m_lo = '0; m_en = 0; m_inv = 0;
      return;
    end
    fire = m_en && (time_now >= m_thr) && !(wr_en && wr_sel == 2'd3);
    if (fire) begin
      m_lvl = ~m_lvl;
      m_thr = m_thr + (m_lvl ? hi_old : lo_old);
    end
    if (wr_en) begin
      case (wr_sel)
        2'd0: begin m_en = wr_data[0]; m_inv = wr_data[1]; end
        2'd1: m_hi = wr_data;
        2'd2: m_lo = wr_data;
        default: m_thr = wr_data;
      endcase
    end
  endtask

  task automatic step(input logic [TW-1:0] dt, input string req);
    logic exp;
    time_now = time_now + dt;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    exp = m_en ? (m_lvl ^ m_inv) : m_inv;
    checks++;
    if (pps_out !== exp) begin
      fails++;
      $display("FAIL %s: pps_out actual %b expected %b at t=%h", req, pps_out, exp, time_now);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [TW-1:0] d, input string req);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    step('0, req);
    wr_en = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    step('0, "R1");
    step('0, "R1");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(NS, "R1");

    // disabled with invert: output idles at invert bit
    wr(2'd0, 64'h2, "R2");
    for (int i = 0; i < 5; i++) step(NS, "R2");

    // sweep of phase lengths with fractional parts, time step 0.75 ns
    for (int h = 1; h <= 3; h++) begin
      for (int l = 1; l <= 3; l++) begin
        wr(2'd0, 64'h0, "R8");
        wr(2'd1, NS * h + 64'h8000_0000, "R8");
        wr(2'd2, NS * l, "R8");
        wr(2'd3, time_now + 2 * NS, "R8");
        wr(2'd0, 64'h1, "R8");
        for (int k = 0; k < 40; k++) step(64'hC000_0000, "R4");
      end
    end

    // enabled and inverted
    wr(2'd0, 64'h3, "R5");
    for (int k = 0; k < 20; k++) step(64'hC000_0000, "R5");

    // late threshold: fires on consecutive edges
    wr(2'd0, 64'h1, "R5");
    wr(2'd1, NS, "R7");
    wr(2'd2, NS, "R7");
    time_now = 100 * NS;
    wr(2'd3, 64'h0, "R7");
    for (int k = 0; k < 30; k++) step('0, "R7");

    // threshold write on a firing edge wins, no flip
    wr(2'd3, time_now + 1000 * NS, "R6");
    for (int k = 0; k < 5; k++) step(NS, "R6");

    // strobe low: port ignored
    wr_sel = 2'd0; wr_data = 64'h0;
    for (int k = 0; k < 3; k++) step('0, "R8");
    wr_sel = 2'd3; wr_data = 64'h0;
    for (int k = 0; k < 3; k++) step('0, "R8");

    // wrap of the threshold past 2^64
    wr(2'd1, 3 * NS, "R4");
    wr(2'd2, 3 * NS, "R4");
    time_now = 64'hFFFF_FFF0_0000_0000;
    wr(2'd3, 64'hFFFF_FFFE_0000_0000, "R4");
    for (int k = 0; k < 40; k++) step(NS, "R4");

    // disable freezes phase, re-enable resumes
    wr(2'd3, time_now + 4 * NS, "R2");
    wr(2'd0, 64'h0, "R2");
    for (int k = 0; k < 20; k++) step(NS, "R2");
    time_now = time_now - 30 * NS;
    wr(2'd0, 64'h1, "R3");
    for (int k = 0; k < 30; k++) step(NS, "R3");

    // reset mid-run
    rst_n = 1'b0;
    step(NS, "R1");
    step(NS, "R1");
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) step(NS, "R1");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule